// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache with Posted Write Queue

This block is a physically addressed, direct-mapped cache whose lines each hold a single 32-bit word. The processor presents a word address (the two byte-offset bits are already stripped, so the address is 30 bits wide), a read/write flag and, for writes, a data word. It holds its request steady for as long as `cpu_stall` is high. A read that finds a valid line with a matching tag returns the stored word in the same cycle. A read that misses stalls while the word is fetched over a simple request/valid memory read port. The fetched word is installed, and the held request then completes as a hit.

Writes never test for a hit. Each accepted write overwrites the indexed line's tag and data, marks the line valid, and posts the address and data into a small FIFO that drains toward memory through a valid/ready port. Because memory is always kept up to date, no line is ever dirty, and replacing a line never produces traffic of its own. A write that finds the queue full waits. A read miss waits until the queue is empty, so it cannot fetch a stale word that is still queued. The full-size organisation uses a 16-bit tag and a 14-bit index; the index width is a parameter and defaults to a smaller array.

Top module: `wt_dm_cache`

## Requirements
- R1: The low `IDX_W` bits of `cpu_addr` select the line and the remaining upper bits form the tag. An address that differs from the cached one only in the index, or only in the tag, misses.
- R2: Reset clears every valid bit. After reset `cpu_stall`, `mem_rd_req` and `wb_valid` are low, and the first read of any address misses.
- R3: A read whose line is valid with a matching tag returns the stored word on `cpu_rdata` with `cpu_stall` low in the same cycle, and it issues no memory read.
- R4: A read miss raises `cpu_stall` and issues one memory read with `mem_rd_addr` equal to the word address. The address is held until `mem_rd_valid`. The word is then installed, `mem_rd_req` drops in the next cycle, and the held read completes with the fetched word.
- R5: An accepted write replaces the indexed line's tag and data and marks it valid, whatever the line held before. A later read of that address hits and returns the written data, and a read of the address that previously occupied the line misses.
- R6: Every accepted write, and nothing else, appears on the drain port in acceptance order with its address and data. The head entry stays stable while `wb_valid` is high and `wb_ready` is low.
- R7: The queue holds `WB_DEPTH` entries. A write presented while the queue is full keeps `cpu_stall` high until the drain port takes an entry.
- R8: `mem_rd_req` is never high while the write queue holds an entry. A read miss that arrives while the queue is not empty stalls without a memory read until the queue has drained.
- R9: While `cpu_req` is low, `cpu_stall` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address: tag in the upper bits, index in the low IDX_W bits |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid when a read request is not stalled |
| cpu_stall | output | 1 | Request cannot complete this cycle |
| mem_rd_req | output | 1 | Line fill read request |
| mem_rd_addr | output | ADDR_W | Word address of the fill |
| mem_rd_valid | input | 1 | Fill data present this cycle |
| mem_rd_data | input | DATA_W | Fill data |
| wb_valid | output | 1 | Write queue head is present |
| wb_addr | output | ADDR_W | Address of the queue head |
| wb_data | output | DATA_W | Data of the queue head |
| wb_ready | input | 1 | Memory accepts the queue head this cycle |

## Verification
Reads run against a small pool of tags and indexes, so hits, cold misses and conflict evictions all occur. Those hits and misses separate the tag and the index, and they show whether a miss installs the line. Writes to a line that holds a different tag show that the write path ignores the hit test. The drain port is throttled at random and also held shut. That separates full-queue write stalls from read misses that wait for the queue to empty, and it checks that the queued order and contents match the accepted writes. The fill latency also varies, so the bench can show that the fill address is held and that data is taken only when `mem_rd_valid` arrives.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
// Shared types for the write-through cache.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package wtc_pkg;
    typedef enum logic [0:0] {
        FILL_IDLE = 1'b0,
        FILL_BUSY = 1'b1
    } fill_state_t;
endpackage

// File: rtl/wtc_line_store.sv
`timescale 1ns/1ps
// Valid, tag and data arrays of the direct-mapped cache, plus the hit compare.
// Assumes: one write port, used for both processor writes and line fills.
// Only the valid bits are reset; tag and data are qualified by valid.
module wtc_line_store #(
    parameter int TAG_W  = 22,
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    // Valid bits: cleared by reset, set by any line write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and data storage: overwritten on every line write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    // Lookup: hit when the indexed line is valid and its tag matches.
    always_comb begin
        rd_hit  = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_data = data_q[rd_idx];
    end
endmodule

// File: rtl/wtc_write_fifo.sv
`timescale 1ns/1ps
// Posted write queue toward memory, drained through a valid/ready port.
// Assumes: push is asserted only when full is low; push and pop may share a cycle.
module wtc_write_fifo #(
    parameter int AW    = 30,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    output logic          full,
    output logic          empty,
    output logic          head_valid,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    input  logic          head_ready
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [PW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] count_q;
    logic          pop;

    function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Status and head presentation.
    always_comb begin
        full       = (count_q == CW'(DEPTH));
        empty      = (count_q == '0);
        head_valid = !empty;
        head_addr  = addr_q[rd_ptr_q];
        head_data  = data_q[rd_ptr_q];
        pop        = head_valid && head_ready;
    end

    // Entry storage: written at the tail on push.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr_q] <= push_addr;
            data_q[wr_ptr_q] <= push_data;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= next_ptr(wr_ptr_q);
            if (pop)  rd_ptr_q <= next_ptr(rd_ptr_q);
            if (push && !pop)      count_q <= count_q + 1'b1;
            else if (pop && !push) count_q <= count_q - 1'b1;
        end
    end
endmodule

// File: rtl/wtc_fill_ctrl.sv
`timescale 1ns/1ps
// Line fill sequencer: latches the missing address, holds a memory read
// request until data arrives, and pulses install in that cycle.
// Assumes: start is raised only while idle.
module wtc_fill_ctrl
    import wtc_pkg::*;
#(
    parameter int AW = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] miss_addr,
    input  logic          mem_valid,
    output logic          busy,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          install
);
    fill_state_t   state_q;
    logic [AW-1:0] addr_q;

    // Outputs decoded from the state.
    always_comb begin
        busy     = (state_q == FILL_BUSY);
        mem_req  = busy;
        mem_addr = addr_q;
        install  = busy && mem_valid;
    end

    // State: idle -> busy on start, busy -> idle when data arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL_IDLE;
        end else if (start) begin
            state_q <= FILL_BUSY;
        end else if (install) begin
            state_q <= FILL_IDLE;
        end
    end

    // Miss address capture.
    always_ff @(posedge clk) begin
        if (start) addr_q <= miss_addr;
    end
endmodule

// File: rtl/wt_dm_cache.sv
`timescale 1ns/1ps
// Direct-mapped, one-word-line, write-through cache with a posted write queue.
// Assumes: the processor holds its request while cpu_stall is high; memory
// read data arrives on mem_rd_valid while mem_rd_req is high.
module wt_dm_cache #(
    parameter int ADDR_W   = 30,
    parameter int IDX_W    = 8,
    parameter int DATA_W   = 32,
    parameter int WB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    input  logic              wb_ready
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  cpu_idx, ln_wr_idx;
    logic [TAG_W-1:0]  cpu_tag, ln_wr_tag;
    logic [DATA_W-1:0] ln_wr_data;
    logic              ln_hit, ln_wr_en;
    logic              q_full, q_empty;
    logic              fill_busy, fill_install, fill_start, wr_go;

    // Address split and request qualification.
    always_comb begin
        cpu_idx    = cpu_addr[IDX_W-1:0];
        cpu_tag    = cpu_addr[ADDR_W-1:IDX_W];
        fill_start = cpu_req && !cpu_we && !ln_hit && !fill_busy && q_empty;
        wr_go      = cpu_req && cpu_we && !fill_busy && !q_full;
        cpu_stall  = cpu_req && (fill_busy || (cpu_we ? q_full : !ln_hit));
    end

    // Line write source: a fill install or an unconditional processor write.
    always_comb begin
        ln_wr_en   = wr_go || fill_install;
        ln_wr_idx  = fill_install ? mem_rd_addr[IDX_W-1:0]      : cpu_idx;
        ln_wr_tag  = fill_install ? mem_rd_addr[ADDR_W-1:IDX_W] : cpu_tag;
        ln_wr_data = fill_install ? mem_rd_data                 : cpu_wdata;
    end

    wtc_line_store #(
        .TAG_W (TAG_W),
        .IDX_W (IDX_W),
        .DATA_W(DATA_W)
    ) lines_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (cpu_idx),
        .rd_tag (cpu_tag),
        .rd_hit (ln_hit),
        .rd_data(cpu_rdata),
        .wr_en  (ln_wr_en),
        .wr_idx (ln_wr_idx),
        .wr_tag (ln_wr_tag),
        .wr_data(ln_wr_data)
    );

    wtc_write_fifo #(
        .AW   (ADDR_W),
        .DW   (DATA_W),
        .DEPTH(WB_DEPTH)
    ) wq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_go),
        .push_addr (cpu_addr),
        .push_data (cpu_wdata),
        .full      (q_full),
        .empty     (q_empty),
        .head_valid(wb_valid),
        .head_addr (wb_addr),
        .head_data (wb_data),
        .head_ready(wb_ready)
    );

    wtc_fill_ctrl #(
        .AW(ADDR_W)
    ) fill_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (fill_start),
        .miss_addr(cpu_addr),
        .mem_valid(mem_rd_valid),
        .busy     (fill_busy),
        .mem_req  (mem_rd_req),
        .mem_addr (mem_rd_addr),
        .install  (fill_install)
    );
endmodule

// File: rtl/wt_dm_cache_chk.sv
`timescale 1ns/1ps
// Port-level protocol checker for wt_dm_cache, attached with bind.
// Assumes: synchronous active-low reset; all properties disabled in reset.
module wt_dm_cache_chk #(
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_stall,
    input logic              mem_rd_req,
    input logic              mem_rd_valid,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              wb_valid,
    input logic              wb_ready,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [DATA_W-1:0] wb_data
);
    // R4
    fill_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R4
    fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_valid) |=> !mem_rd_req);

    // R6
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));

    // R6
    write_posted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && !cpu_stall) |=> wb_valid);

    // R8
    fill_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !wb_valid);
endmodule

bind wt_dm_cache wt_dm_cache_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .cpu_stall   (cpu_stall),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr (mem_rd_addr),
    .wb_valid    (wb_valid),
    .wb_ready    (wb_ready),
    .wb_addr     (wb_addr),
    .wb_data     (wb_data)
);

// File: tb/wt_dm_cache_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random traffic.
module wt_dm_cache_tb_top;
    localparam int ADDR_W   = 30;
    localparam int IDX_W    = 8;
    localparam int DATA_W   = 32;
    localparam int WB_DEPTH = 4;
    localparam int TAG_W    = ADDR_W - IDX_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cpu_req, cpu_we;
    logic [ADDR_W-1:0] cpu_addr;
    logic [DATA_W-1:0] cpu_wdata, cpu_rdata;
    logic              cpu_stall;
    logic              mem_rd_req, mem_rd_valid;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [DATA_W-1:0] mem_rd_data;
    logic              wb_valid, wb_ready;
    logic [ADDR_W-1:0] wb_addr;
    logic [DATA_W-1:0] wb_data;

    int n_chk  = 0;
    int n_fail = 0;

    logic [DATA_W-1:0]        wr_ref  [logic [ADDR_W-1:0]];
    logic [DATA_W-1:0]        mem_img [logic [ADDR_W-1:0]];
    logic [ADDR_W+DATA_W-1:0] wq [$];
    bit                       mv [1 << IDX_W];
    logic [TAG_W-1:0]         mt [1 << IDX_W];
    bit                       wb_hold = 1'b0;
    bit                       pop_now = 1'b0;
    bit                       saw_req = 1'b0;
    logic [ADDR_W-1:0]        cur_addr = '0;
    int                       lat = 1;

    always #4 clk = ~clk;

    wt_dm_cache #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .WB_DEPTH(WB_DEPTH)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .wb_ready(wb_ready)
    );

    function automatic logic [DATA_W-1:0] pattern(input logic [ADDR_W-1:0] a);
        return DATA_W'(32'(a) * 32'h9E37_79B1 + 32'h1234_5678);
    endfunction

    function automatic logic [DATA_W-1:0] ref_val(input logic [ADDR_W-1:0] a);
        return wr_ref.exists(a) ? wr_ref[a] : pattern(a);
    endfunction

    function automatic logic [DATA_W-1:0] img_val(input logic [ADDR_W-1:0] a);
        return mem_img.exists(a) ? mem_img[a] : pattern(a);
    endfunction

    function automatic logic [ADDR_W-1:0] mk(input int t, input int i);
        return (ADDR_W'(t) << IDX_W) | ADDR_W'(i % (1 << IDX_W));
    endfunction

    function automatic bit model_hit(input logic [ADDR_W-1:0] a);
        return mv[a[IDX_W-1:0]] && (mt[a[IDX_W-1:0]] == a[ADDR_W-1:IDX_W]);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Memory read responder with variable latency.
    initial begin
        mem_rd_valid = 1'b0;
        mem_rd_data  = '0;
        forever begin
            @(negedge clk);
            if (mem_rd_valid) begin
                mem_rd_valid = 1'b0;
            end else if (mem_rd_req) begin
                saw_req = 1'b1;
                if (lat == 0) begin
                    chk(!wb_valid, "R8", "fill while queue holds entry", 64'(wb_valid), 64'd0);
                    chk(mem_rd_addr == cur_addr, "R4", "fill address",
                        64'(mem_rd_addr), 64'(cur_addr));
                    mem_rd_data  = img_val(mem_rd_addr);
                    mem_rd_valid = 1'b1;
                    lat = int'($urandom % 3);
                end else begin
                    lat--;
                end
            end
        end
    end

    // Drain port: random ready unless held; checks order and contents.
    initial begin
        wb_ready = 1'b0;
        forever begin
            @(negedge clk);
            pop_now  = 1'b0;
            wb_ready = !wb_hold && ($urandom % 2 == 0);
            #1;
            if (wb_valid && wb_ready) begin
                pop_now = 1'b1;
                if (wq.size() == 0) begin
                    chk(1'b0, "R6", "unexpected drain entry", 64'(wb_addr), 64'd0);
                end else begin
                    logic [ADDR_W+DATA_W-1:0] e;
                    e = wq.pop_front();
                    chk({wb_addr, wb_data} == e, "R6", "drain entry",
                        64'({wb_addr, wb_data}), 64'(e));
                end
                mem_img[wb_addr] = wb_data;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WD", "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    task automatic drive(input bit we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        cur_addr = a; saw_req = 1'b0;
        #2;
    endtask

    task automatic wait_done();
        int n = 0;
        while (cpu_stall && n < 300) begin
            @(negedge clk); #2; n++;
        end
    endtask

    task automatic read_finish(input logic [ADDR_W-1:0] a, input string lab, input bit exp_hit);
        wait_done();
        chk(!cpu_stall, lab, "read completes", 64'(cpu_stall), 64'd0);
        chk(saw_req == !exp_hit, lab, "memory read issued", 64'(saw_req), 64'(!exp_hit));
        chk(cpu_rdata == ref_val(a), wr_ref.exists(a) ? "R5" : lab, "read data",
            64'(cpu_rdata), 64'(ref_val(a)));
        mv[a[IDX_W-1:0]] = 1'b1;
        mt[a[IDX_W-1:0]] = a[ADDR_W-1:IDX_W];
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input string lbl);
        bit    exp_hit;
        string lab;
        exp_hit = model_hit(a);
        lab = (lbl != "") ? lbl : (exp_hit ? "R3" : "R4");
        drive(1'b0, a, '0);
        chk(cpu_stall == !exp_hit, lab, "stall on read", 64'(cpu_stall), 64'(!exp_hit));
        read_finish(a, lab, exp_hit);
    endtask

    task automatic write_finish(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        wait_done();
        wq.push_back({a, d});
        wr_ref[a] = d;
        mv[a[IDX_W-1:0]] = 1'b1;
        mt[a[IDX_W-1:0]] = a[ADDR_W-1:IDX_W];
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string lbl);
        bit    exp_full;
        drive(1'b1, a, d);
        exp_full = (wq.size() + int'(pop_now)) >= WB_DEPTH;
        chk(cpu_stall == exp_full, (lbl != "") ? lbl : (exp_full ? "R7" : "R5"),
            "stall on write", 64'(cpu_stall), 64'(exp_full));
        write_finish(a, d);
    endtask

    task automatic drain_all();
        wb_hold = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        for (int i = 0; i < (1 << IDX_W); i++) mv[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(!cpu_stall, "R2", "stall after reset", 64'(cpu_stall), 64'd0);
        chk(!mem_rd_req, "R2", "mem_rd_req after reset", 64'(mem_rd_req), 64'd0);
        chk(!wb_valid, "R2", "wb_valid after reset", 64'(wb_valid), 64'd0);

        // Cold miss, then hit.
        do_read(mk(0, 21), "R2");
        do_read(mk(0, 21), "R3");
        // Tag/index separation.
        do_read(mk(0, 22), "R1");
        do_read(mk(1, 21), "R1");
        do_read(mk(0, 21), "R1");
        // Write over a line holding another tag.
        do_read(mk(2, 32), "R4");
        do_write(mk(3, 32), 32'hCAFE_0001, "R5");
        do_read(mk(3, 32), "R5");
        do_read(mk(2, 32), "R5");

        // Full queue stalls writes.
        drain_all();
        wb_hold = 1'b1;
        for (int k = 0; k < WB_DEPTH; k++) do_write(mk(5, 40 + k), 32'hA000_0000 + k, "R7");
        drive(1'b1, mk(5, 50), 32'hBEEF_0050);
        chk(cpu_stall, "R7", "write stalls when full", 64'(cpu_stall), 64'd1);
        repeat (3) begin
            @(negedge clk); #2;
            chk(cpu_stall, "R7", "stall held while full", 64'(cpu_stall), 64'd1);
        end
        wb_hold = 1'b0;
        write_finish(mk(5, 50), 32'hBEEF_0050);

        // Read miss waits for the queue to empty.
        drain_all();
        wb_hold = 1'b1;
        do_write(mk(6, 60), 32'h6060_6060, "R8");
        drive(1'b0, mk(7, 61), '0);
        chk(cpu_stall, "R8", "miss stalls with queue busy", 64'(cpu_stall), 64'd1);
        repeat (4) begin
            @(negedge clk); #2;
            chk(!mem_rd_req, "R8", "no fill with queue busy", 64'(mem_rd_req), 64'd0);
        end
        wb_hold = 1'b0;
        read_finish(mk(7, 61), "R8", 1'b0);

        // Idle.
        repeat (3) begin
            @(negedge clk); #2;
            chk(!cpu_stall, "R9", "stall while idle", 64'(cpu_stall), 64'd0);
        end

        // Seeded random traffic over a small address pool.
        for (int n = 0; n < 800; n++) begin
            int unsigned r;
            logic [ADDR_W-1:0] a;
            r = $urandom % 10;
            a = mk(int'($urandom % 4), int'($urandom % 16));
            if (r == 0) begin
                @(negedge clk); #2;
                chk(!cpu_stall, "R9", "stall while idle", 64'(cpu_stall), 64'd0);
            end else if (r < 5) begin
                do_write(a, $urandom, "");
            end else begin
                do_read(a, "");
            end
        end

        drain_all();
        chk(wq.size() == 0, "R6", "queue fully drained", 64'(wq.size()), 64'd0);
        finish_run();
    end
endmodule